// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit decides where a 64-bit processor with fixed 4-byte instructions fetches next. On every clock it takes the current program counter, the 32-bit instruction word and the values read from the two source registers (A and B). It classifies the instruction as sequential, conditional branch or register jump, and evaluates the branch condition against register A. It then registers the next program counter, a redirect flag and, for jumps, a return-address write to the register file.

Conditional branches test register A against zero, either by sign or by its low bit. A taken branch lands on the address after the branch plus a scaled, sign-extended 21-bit word displacement. A register jump goes to the address held in register B, with the two low bits cleared. It writes the return address into the register named by the A field unless that field names the hard-wired zero register. Every other instruction advances by 4.

The decision logic is a single enumerated instruction class (sequential, branch, jump) chosen by a unique case. The result is held in one register stage, so outputs appear exactly one clock after the inputs are presented. Transitions are class selections: SEQ goes to pc+4, BRANCH goes to the target or pc+4, and JUMP goes to the register target plus a link write.

Top module: `npc_unit`

## Requirements
- R1: While rst_i is high, at the next clock edge next_pc_o, link_val_o and link_rd_o become zero and taken_o and link_we_o become 0.
- R2: An instruction that is neither a branch nor a jump gives next_pc_o = pc_i + 4, taken_o = 0 and link_we_o = 0.
- R3: Bits [31:29] equal to 3'b111 mark a conditional branch, and bits [28:26] select its condition: 0 low-bit-clear, 1 equal-zero, 2 less-than-zero, 3 less-or-equal-zero, 4 low-bit-set, 5 not-equal-zero, 6 greater-or-equal-zero, 7 greater-than-zero.
- R4: The equal-zero and not-equal-zero conditions test whether all 64 bits of ra_val_i are zero.
- R5: The less-than, less-or-equal, greater-or-equal and greater-than conditions treat ra_val_i as signed two's complement.
- R6: Low-bit-clear is true when ra_val_i[0] is 0, and low-bit-set is true when ra_val_i[0] is 1.
- R7: A branch whose condition holds gives taken_o = 1 and next_pc_o = pc_i + 4 + 4 * sign-extended bits [20:0]. A branch whose condition fails gives taken_o = 0 and next_pc_o = pc_i + 4. A branch never sets link_we_o.
- R8: Opcode 6'h1A in bits [31:26] is a register jump: taken_o = 1 and next_pc_o = rb_val_i with bits [1:0] cleared.
- R9: A jump drives link_val_o = pc_i + 4 and link_rd_o = bits [25:21]. It sets link_we_o = 1 unless those bits equal 31, in which case link_we_o = 0.
- R10: Bits [15:0] of a jump have no effect on any output.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge (one cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_i | input | 64 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| ra_val_i | input | 64 | Value of source register A |
| rb_val_i | input | 64 | Value of source register B |
| next_pc_o | output | 64 | Registered next program counter |
| taken_o | output | 1 | Flow redirected (taken branch or jump) |
| link_we_o | output | 1 | Return-address write enable |
| link_rd_o | output | 5 | Return-address destination register |
| link_val_o | output | 64 | Return address (pc + 4) |

## Verification
The bench builds the unit with its default parameters: 64-bit data, 32-bit instructions, 5-bit register indices, a 21-bit displacement, jump opcode 0x1A and zero register 31. At these values the most negative and most positive displacements reach the full signed range. Register A values at the sign bit (bit 63) and at bit 0 test the signed and low-bit conditions at their edges. A program counter near the top of the 64-bit space lets pc+4 and the branch target wrap.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        CLS_SEQ    = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_JUMP   = 2'd2
    } instr_class_e;

    typedef enum logic [2:0] {
        C_LBC = 3'd0,
        C_EQ  = 3'd1,
        C_LT  = 3'd2,
        C_LE  = 3'd3,
        C_LBS = 3'd4,
        C_NE  = 3'd5,
        C_GE  = 3'd6,
        C_GT  = 3'd7
    } br_cond_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int INSTR_W   = 32,
    parameter int OPC_W     = 6,
    parameter int REG_IDX_W = 5,
    parameter int DISP_W    = 21,
    parameter logic [OPC_W-1:0] JUMP_OPC = 6'h1A
) (
    input  logic [INSTR_W-1:0]   instr_i,
    output instr_class_e         cls_o,
    output br_cond_e             cond_o,
    output logic [REG_IDX_W-1:0] ra_idx_o,
    output logic [DISP_W-1:0]    disp_o
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RA_LSB  = OPC_LSB - REG_IDX_W;
    localparam int GRP_W   = OPC_W - 3;

    logic [OPC_W-1:0] opc;

    assign opc      = instr_i[INSTR_W-1:OPC_LSB];
    assign ra_idx_o = instr_i[RA_LSB +: REG_IDX_W];
    assign disp_o   = instr_i[DISP_W-1:0];
    assign cond_o   = br_cond_e'(opc[2:0]);

    always_comb begin
        if (opc[OPC_W-1 -: GRP_W] == {GRP_W{1'b1}}) begin
            cls_o = CLS_BRANCH;
        end else if (opc == JUMP_OPC) begin
            cls_o = CLS_JUMP;
        end else begin
            cls_o = CLS_SEQ;
        end
    end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  br_cond_e        cond_i,
    input  logic [XLEN-1:0] a_i,
    output logic            pass_o
);
    logic is_zero;
    logic is_neg;
    logic low_bit;

    assign is_zero = (a_i == '0);
    assign is_neg  = a_i[XLEN-1];
    assign low_bit = a_i[0];

    always_comb begin
        unique case (cond_i)
            C_LBC:   pass_o = !low_bit;
            C_EQ:    pass_o = is_zero;
            C_LT:    pass_o = is_neg;
            C_LE:    pass_o = is_neg || is_zero;
            C_LBS:   pass_o = low_bit;
            C_NE:    pass_o = !is_zero;
            C_GE:    pass_o = !is_neg;
            C_GT:    pass_o = !is_neg && !is_zero;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 21,
    parameter int ILEN_B = 4
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [XLEN-1:0]   rb_i,
    output logic [XLEN-1:0]   seq_pc_o,
    output logic [XLEN-1:0]   br_target_o,
    output logic [XLEN-1:0]   jmp_target_o
);
    localparam int SHIFT = $clog2(ILEN_B);
    localparam int EXT_W = XLEN - DISP_W - SHIFT;

    logic [XLEN-1:0] disp_bytes;

    assign disp_bytes   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, {SHIFT{1'b0}}};
    assign seq_pc_o     = pc_i + XLEN'(ILEN_B);
    assign br_target_o  = seq_pc_o + disp_bytes;
    assign jmp_target_o = rb_i & ~XLEN'(ILEN_B - 1);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int INSTR_W   = 32,
    parameter int REG_IDX_W = 5,
    parameter int DISP_W    = 21,
    parameter int ZERO_REG  = 31,
    parameter logic [5:0] JUMP_OPC = 6'h1A
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [XLEN-1:0]      pc_i,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic [XLEN-1:0]      ra_val_i,
    input  logic [XLEN-1:0]      rb_val_i,
    output logic [XLEN-1:0]      next_pc_o,
    output logic                 taken_o,
    output logic                 link_we_o,
    output logic [REG_IDX_W-1:0] link_rd_o,
    output logic [XLEN-1:0]      link_val_o
);
    localparam logic [REG_IDX_W-1:0] ZERO_IDX = REG_IDX_W'(ZERO_REG);

    instr_class_e         cls;
    br_cond_e             cond;
    logic [REG_IDX_W-1:0] ra_idx;
    logic [DISP_W-1:0]    disp;
    logic                 cond_pass;
    logic [XLEN-1:0]      seq_pc, br_target, jmp_target;

    logic [XLEN-1:0] nxt_pc;
    logic            nxt_taken;
    logic            nxt_we;
    logic            out_live;

    npc_decode #(
        .INSTR_W(INSTR_W), .OPC_W(6), .REG_IDX_W(REG_IDX_W),
        .DISP_W(DISP_W), .JUMP_OPC(JUMP_OPC)
    ) decode_i (
        .instr_i(instr_i), .cls_o(cls), .cond_o(cond),
        .ra_idx_o(ra_idx), .disp_o(disp)
    );

    npc_cond_eval #(.XLEN(XLEN)) cond_i (
        .cond_i(cond), .a_i(ra_val_i), .pass_o(cond_pass)
    );

    npc_target #(.XLEN(XLEN), .DISP_W(DISP_W), .ILEN_B(4)) target_i (
        .pc_i(pc_i), .disp_i(disp), .rb_i(rb_val_i),
        .seq_pc_o(seq_pc), .br_target_o(br_target), .jmp_target_o(jmp_target)
    );

    // Output selection per instruction class
    always_comb begin
        nxt_pc    = seq_pc;
        nxt_taken = 1'b0;
        nxt_we    = 1'b0;
        unique case (cls)
            CLS_BRANCH: begin
                nxt_taken = cond_pass;
                nxt_pc    = cond_pass ? br_target : seq_pc;
            end
            CLS_JUMP: begin
                nxt_taken = 1'b1;
                nxt_pc    = jmp_target;
                nxt_we    = (ra_idx != ZERO_IDX);
            end
            default: begin
                nxt_pc = seq_pc;
            end
        endcase
    end

    // Result register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            next_pc_o  <= '0;
            taken_o    <= 1'b0;
            link_we_o  <= 1'b0;
            link_rd_o  <= '0;
            link_val_o <= '0;
            out_live   <= 1'b0;
        end else begin
            next_pc_o  <= nxt_pc;
            taken_o    <= nxt_taken;
            link_we_o  <= nxt_we;
            link_rd_o  <= ra_idx;
            link_val_o <= seq_pc;
            out_live   <= 1'b1;
        end
    end

    a_r2_seq_advance: assert property (@(posedge clk_i) disable iff (rst_i)
        out_live && $past(cls) == CLS_SEQ |->
            next_pc_o == $past(pc_i) + 64'd4 && !taken_o && !link_we_o);

    a_r7_not_taken_is_seq: assert property (@(posedge clk_i) disable iff (rst_i)
        out_live && !taken_o |-> next_pc_o == $past(pc_i) + 64'd4);

    a_r7_branch_no_link: assert property (@(posedge clk_i) disable iff (rst_i)
        out_live && $past(cls) == CLS_BRANCH |-> !link_we_o);

    a_r8_jump_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        out_live && $past(cls) == CLS_JUMP |-> taken_o && next_pc_o[1:0] == 2'b00);

    a_r9_no_zero_link: assert property (@(posedge clk_i) disable iff (rst_i)
        link_we_o |-> link_rd_o != ZERO_IDX);

    a_r9_link_value: assert property (@(posedge clk_i) disable iff (rst_i)
        out_live && link_we_o |-> link_val_o == $past(pc_i) + 64'd4);

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] pc, ra_v, rb_v;
    logic [31:0] instr;
    logic [63:0] next_pc, link_val;
    logic        taken, link_we;
    logic [4:0]  link_rd;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    npc_unit dut_i (
        .clk_i(clk), .rst_i(rst), .pc_i(pc), .instr_i(instr),
        .ra_val_i(ra_v), .rb_val_i(rb_v), .next_pc_o(next_pc),
        .taken_o(taken), .link_we_o(link_we), .link_rd_o(link_rd),
        .link_val_o(link_val)
    );

    function automatic logic [31:0] br(input int cnd, input int disp);
        logic [20:0] d = 21'(disp);
        return {3'b111, 3'(cnd), 5'd4, d};
    endfunction

    function automatic logic [31:0] jmp(input int ra, input int rb, input int hint);
        return {6'h1A, 5'(ra), 5'(rb), 16'(hint)};
    endfunction

    // Behavioural reference: returns next pc, taken, link write
    task automatic model(input logic [63:0] p, input logic [31:0] w,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] e_pc, output logic e_tk,
                         output logic e_we);
        longint sa = a;
        bit c;
        e_pc = p + 64'd4; e_tk = 0; e_we = 0;
        if (w[31:29] == 3'b111) begin
            case (w[28:26])
                3'd0: c = (a % 2) == 0;
                3'd1: c = sa == 0;
                3'd2: c = sa < 0;
                3'd3: c = sa <= 0;
                3'd4: c = (a % 2) == 1;
                3'd5: c = sa != 0;
                3'd6: c = sa >= 0;
                default: c = sa > 0;
            endcase
            if (c) begin
                e_tk = 1;
                e_pc = p + 64'd4 + 64'(longint'($signed(w[20:0])) * 4);
            end
        end else if (w[31:26] == 6'h1A) begin
            e_tk = 1;
            e_pc = (b / 4) * 4;
            e_we = (w[25:21] != 5'd31);
        end
    endtask

    task automatic apply(input string req, input logic [63:0] p, input logic [31:0] w,
                         input logic [63:0] a, input logic [63:0] b);
        logic [63:0] e_pc;
        logic e_tk, e_we;
        model(p, w, a, b, e_pc, e_tk, e_we);
        pc = p; instr = w; ra_v = a; rb_v = b;
        @(negedge clk);
        checks++;
        if (next_pc !== e_pc || taken !== e_tk || link_we !== e_we) begin
            failures++;
            $display("FAIL %s pc=%h tk=%b we=%b expected pc=%h tk=%b we=%b",
                     req, next_pc, taken, link_we, e_pc, e_tk, e_we);
        end
        if (e_we) begin
            checks++;
            if (link_rd !== w[25:21] || link_val !== p + 64'd4) begin
                failures++;
                $display("FAIL %s link rd=%0d val=%h expected rd=%0d val=%h",
                         req, link_rd, link_val, w[25:21], p + 64'd4);
            end
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; pc = 64'h1000; instr = jmp(26, 1, 0); ra_v = 0; rb_v = 64'h55;
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (next_pc !== 0 || taken !== 0 || link_we !== 0 || link_rd !== 0 || link_val !== 0) begin
            failures++;
            $display("FAIL R1 reset pc=%h tk=%b we=%b expected all zero", next_pc, taken, link_we);
        end
        rst = 0;

        // R2 sequential
        apply("R2", 64'h0000_0001_2000_12d0, 32'h4211_0401, 64'd5, 64'd9);
        apply("R2", 64'hFFFF_FFFF_FFFF_FFFC, 32'h6C00_0000, 64'd0, 64'd0);
        // R3 / R4 equal and not-equal zero
        apply("R4", 64'h2000, br(1, 16), 64'd0, 0);
        apply("R4", 64'h2000, br(1, 16), 64'h8000_0000_0000_0000, 0);
        apply("R4", 64'h2000, br(5, -3), 64'h8000_0000_0000_0000, 0);
        apply("R4", 64'h2000, br(5, -3), 64'd0, 0);
        // R5 signed compares
        apply("R5", 64'h3000, br(2, 7), 64'hFFFF_FFFF_FFFF_FFFF, 0);
        apply("R5", 64'h3000, br(2, 7), 64'h7FFF_FFFF_FFFF_FFFF, 0);
        apply("R5", 64'h3000, br(3, 7), 64'd0, 0);
        apply("R5", 64'h3000, br(3, 7), 64'd1, 0);
        apply("R5", 64'h3000, br(6, 7), 64'd0, 0);
        apply("R5", 64'h3000, br(6, 7), 64'h8000_0000_0000_0000, 0);
        apply("R5", 64'h3000, br(7, 7), 64'd0, 0);
        apply("R5", 64'h3000, br(7, 7), 64'd2, 0);
        // R6 low-bit tests
        apply("R6", 64'h4000, br(0, 2), 64'h8000_0000_0000_0002, 0);
        apply("R6", 64'h4000, br(0, 2), 64'd3, 0);
        apply("R6", 64'h4000, br(4, 2), 64'd3, 0);
        apply("R6", 64'h4000, br(4, 2), 64'd0, 0);
        // R7 displacement extremes and wrap
        apply("R7", 64'h10_0000, br(1, 1048575), 64'd0, 0);
        apply("R7", 64'h10_0000, br(1, -1048576), 64'd0, 0);
        apply("R7", 64'hFFFF_FFFF_FFFF_FFF8, br(1, 1), 64'd0, 0);
        apply("R7", 64'h10, br(1, -5), 64'd0, 0);
        // R8 / R9 jumps and link
        apply("R8", 64'h5000, jmp(26, 1, 0), 0, 64'h1234_5678_9ABC_DEF3);
        apply("R9", 64'h5004, jmp(31, 26, 0), 0, 64'h0000_0000_0000_0084);
        apply("R9", 64'hFFFF_FFFF_FFFF_FFFC, jmp(0, 2, 0), 0, 64'h40);
        // R10 hint bits ignored
        apply("R10", 64'h5000, jmp(26, 1, 16'hFFFF), 0, 64'h1234_5678_9ABC_DEF3);
        apply("R10", 64'h5004, jmp(31, 26, 16'hA5A5), 0, 64'h84);
        // R11 back-to-back latency: alternate classes each cycle
        for (int i = 0; i < 8; i++) begin
            apply("R11", 64'(i * 64), (i % 2 == 0) ? br(2, i) : jmp(i, 3, i),
                  64'(-i), 64'(i * 1000 + 7));
        end
        finish_run();
    end

endmodule